// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the sequence of column addresses that a synchronous DRAM walks through during one burst. A memory controller or a behavioural memory model uses it to know which column each data beat belongs to. A one-cycle start pulse loads the first column, the burst length code, the ordering bit and the access kind. The block then presents one column per beat and moves on to the next beat on each cycle in which the advance strobe is high.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that size. Sequential ordering counts the low column bits upward and wraps them. Interleaved ordering XORs the low start bits with the beat number. Full-page bursts count through all 256 columns modulo 256 and end only on a stop. The block can force write bursts to a single beat.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, beat_vld_o, last_o and col_o are all zero.
- R2: The cycle after start_i is sampled high, beat_vld_o is 1 and col_o equals the start_col_i value captured with the pulse.
- R3: blen_code_i selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 give 1 beat.
- R4: With itlv_i = 0 and length N, beat k shows the start column with its low log2(N) bits replaced by (start low bits + k) mod N. The upper bits never change.
- R5: With itlv_i = 1 and fixed length N, beat k shows the start column with its low log2(N) bits XORed with k.
- R6: In full-page mode, beat k shows (start column + k) mod 256, itlv_i is ignored, and last_o is never asserted.
- R7: For fixed lengths, last_o is high exactly on beat N-1. An advance on that beat makes beat_vld_o drop in the next cycle.
- R8: While adv_i is low and no stop or start is presented, col_o and the beat position hold.
- R9: stop_i sampled high during a valid beat makes beat_vld_o drop in the next cycle.
- R10: The length, ordering and access-kind settings are captured at start_i. Changes on blen_code_i, itlv_i, wr_i and wr_single_i during a burst have no effect on its columns or its end.
- R11: When wr_i and wr_single_i are both high at start, the burst is one beat long, whatever the length code. With wr_single_i low, a write uses the coded length.
- R12: start_i has priority over stop_i and adv_i. A start during a running burst begins the new burst in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle burst start pulse |
| start_col_i | input | 8 | First column of the burst |
| blen_code_i | input | 3 | Burst length code (see R3) |
| itlv_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| wr_i | input | 1 | Burst is a write |
| wr_single_i | input | 1 | Force write bursts to one beat |
| adv_i | input | 1 | Consume current beat and move to the next |
| stop_i | input | 1 | Burst stop |
| col_o | output | 8 | Column of the current beat |
| beat_vld_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Two situations are hard to reach from the ports. The first is the interaction of a new start with a burst that is still running, while the configuration inputs are being changed underneath it. The stimulus covers this by raising start_i on a middle beat of an eight-beat burst. It also drives inverted length and ordering values on every cycle after each start, so that a design which samples them late produces wrong columns. The second is the full-page wrap from column 255 to 0. A full-page burst started near the top of the page, with the ordering bit set, crosses that boundary before a stop ends it. Single-cycle advance stalls are inserted so that holding a beat is checked against advancing it.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int COL_W  = 8;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] BL_1    = 3'b000;
  localparam logic [CODE_W-1:0] BL_2    = 3'b001;
  localparam logic [CODE_W-1:0] BL_4    = 3'b010;
  localparam logic [CODE_W-1:0] BL_8    = 3'b011;
  localparam logic [CODE_W-1:0] BL_PAGE = 3'b111;

  typedef struct packed {
    logic [COL_W-1:0] mask;
    logic             full;
    logic             ilv;
  } burst_cfg_t;

  function automatic logic [COL_W-1:0] len_mask(input logic [CODE_W-1:0] code);
    case (code)
      BL_2:    return COL_W'(1);
      BL_4:    return COL_W'(3);
      BL_8:    return COL_W'(7);
      BL_PAGE: return {COL_W{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic burst_cfg_t decode_cfg(input logic [CODE_W-1:0] code,
                                            input logic ilv, input logic wr,
                                            input logic wr_single);
    burst_cfg_t c;
    if (wr && wr_single) begin
      c.mask = '0;
      c.full = 1'b0;
      c.ilv  = 1'b0;
    end else begin
      c.mask = len_mask(code);
      c.full = (code == BL_PAGE);
      c.ilv  = ilv && (code != BL_PAGE);
    end
    return c;
  endfunction

  function automatic logic [COL_W-1:0] seq_low(input logic [COL_W-1:0] base,
                                               input logic [COL_W-1:0] beat);
    return base + beat;
  endfunction
endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int KW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] start_col_i,
  input  logic [KW-1:0] blen_code_i,
  input  logic          itlv_i,
  input  logic          wr_i,
  input  logic          wr_single_i,
  input  logic          adv_i,
  input  logic          stop_i,
  output logic          vld_o,
  output logic          last_o,
  output logic [CW-1:0] base_o,
  output logic [CW-1:0] beat_o,
  output burst_cfg_t    cfg_o
);
  logic          vld_q;
  logic [CW-1:0] beat_q;
  logic [CW-1:0] base_q;
  burst_cfg_t    cfg_q;
  burst_cfg_t    cfg_new;
  logic          at_end;

  assign cfg_new = decode_cfg(blen_code_i, itlv_i, wr_i, wr_single_i);
  assign at_end  = vld_q && !cfg_q.full && (beat_q == cfg_q.mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      cfg_q  <= '0;
    end else if (start_i) begin
      vld_q  <= 1'b1;
      beat_q <= '0;
      base_q <= start_col_i;
      cfg_q  <= cfg_new;
    end else if (vld_q && stop_i) begin
      vld_q  <= 1'b0;
    end else if (vld_q && adv_i) begin
      if (at_end) vld_q <= 1'b0;
      else        beat_q <= beat_q + 1'b1;
    end
  end

  assign vld_o  = vld_q;
  assign last_o = at_end;
  assign base_o = base_q;
  assign beat_o = beat_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int CW = COL_W
) (
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] beat_i,
  input  logic [CW-1:0] mask_i,
  input  logic          ilv_i,
  output logic [CW-1:0] col_o
);
  logic [CW-1:0] sum_w;
  assign sum_w = seq_low(base_i, beat_i);

  for (genvar b = 0; b < CW; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])  col_o[b] = base_i[b];
      else if (ilv_i)  col_o[b] = base_i[b] ^ beat_i[b];
      else             col_o[b] = sum_w[b];
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int CW = COL_W,
  parameter int KW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] start_col_i,
  input  logic [KW-1:0] blen_code_i,
  input  logic          itlv_i,
  input  logic          wr_i,
  input  logic          wr_single_i,
  input  logic          adv_i,
  input  logic          stop_i,
  output logic [CW-1:0] col_o,
  output logic          beat_vld_o,
  output logic          last_o
);
  logic [CW-1:0] base_w;
  logic [CW-1:0] beat_w;
  burst_cfg_t    cfg_w;
  logic [CW-1:0] mask_w;
  logic          full_w;
  logic          ilv_w;

  colgen_ctrl #(.CW(CW), .KW(KW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_code_i(blen_code_i), .itlv_i(itlv_i), .wr_i(wr_i),
    .wr_single_i(wr_single_i), .adv_i(adv_i), .stop_i(stop_i),
    .vld_o(beat_vld_o), .last_o(last_o), .base_o(base_w), .beat_o(beat_w),
    .cfg_o(cfg_w)
  );

  assign mask_w = cfg_w.mask;
  assign full_w = cfg_w.full;
  assign ilv_w  = cfg_w.ilv;

  colgen_addr #(.CW(CW)) u_addr (
    .base_i(base_w), .beat_i(beat_w), .mask_i(mask_w), .ilv_i(ilv_w),
    .col_o(col_o)
  );
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [CW-1:0] start_col_i,
  input logic          adv_i,
  input logic          stop_i,
  input logic [CW-1:0] col_o,
  input logic          beat_vld_o,
  input logic          last_o,
  input logic [CW-1:0] mask_w,
  input logic          full_w
);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> beat_vld_o && col_o == $past(start_col_i));

  a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    full_w |-> !last_o);

  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && adv_i && !start_i |=> !beat_vld_o);

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_vld_o);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && !adv_i && !stop_i && !start_i |=> beat_vld_o && $stable(col_o));

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && stop_i && !start_i |=> !beat_vld_o);

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && adv_i && !last_o && !stop_i && !start_i
      |=> (col_o & ~$past(mask_w)) == ($past(col_o) & ~$past(mask_w)));
endmodule

bind sdram_burst_colgen colgen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
  .adv_i(adv_i), .stop_i(stop_i), .col_o(col_o), .beat_vld_o(beat_vld_o),
  .last_o(last_o), .mask_w(mask_w), .full_w(full_w)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] blen_code_i = '0;
  logic       itlv_i = 1'b0, wr_i = 1'b0, wr_single_i = 1'b0;
  logic       adv_i = 1'b0, stop_i = 1'b0;
  logic [7:0] col_o;
  logic       beat_vld_o, last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int    col;
    bit    last;
    string tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] nxt_col;
  logic [2:0] nxt_code;
  bit         nxt_ilv;

  always #2.5 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_code_i(blen_code_i), .itlv_i(itlv_i), .wr_i(wr_i),
    .wr_single_i(wr_single_i), .adv_i(adv_i), .stop_i(stop_i),
    .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int beats_of(input logic [2:0] code, input bit wr, input bit wrs);
    if (wr && wrs) return 1;
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int c, input int n, input bit ilv, input int k);
    int lo, hi;
    if (n == 256) return (c + k) % 256;
    lo = c % n;
    hi = c - lo;
    if (ilv) return hi + (lo ^ k);
    return hi + ((lo + k) % n);
  endfunction

  // endmode: 0 natural end, 1 stop on final beat, 2 restart on final beat
  task automatic run(input logic [7:0] c, input logic [2:0] code, input bit ilv,
                     input bit wr, input bit wrs, input int beats, input int endmode,
                     input bit stall, input bit pre, input string tag);
    int n;
    n = beats_of(code, wr, wrs);
    for (int k = 0; k < beats; k++) begin
      exp_t e;
      e.col  = exp_col(c, n, ilv, k);
      e.last = (n != 256) && (k == n - 1);
      e.tag  = tag;
      sb.push_back(e);
    end
    if (!pre) begin
      start_i = 1; start_col_i = c; blen_code_i = code; itlv_i = ilv;
      wr_i = wr; wr_single_i = wrs;
      @(posedge clk); #1;
    end
    start_i = 0;
    blen_code_i = ~code; itlv_i = ~ilv; wr_i = ~wr; wr_single_i = ~wrs;  // R10 scramble
    for (int k = 0; k < beats; k++) begin
      if (stall && k == 1) begin
        adv_i = 0; stop_i = 0;
        @(posedge clk); #1;
      end
      adv_i = 1; stop_i = 0;
      if (k == beats - 1 && endmode == 1) begin adv_i = 0; stop_i = 1; end
      if (k == beats - 1 && endmode == 2) begin
        adv_i = 0; start_i = 1; start_col_i = nxt_col; blen_code_i = nxt_code;
        itlv_i = nxt_ilv; wr_i = 0; wr_single_i = 0;
      end
      @(posedge clk); #1;
    end
    adv_i = 0; stop_i = 0;
    if (endmode != 2) begin
      @(negedge clk);
      chk(!beat_vld_o, {tag, " burst end (R7/R9)"}, beat_vld_o, 0);
      chk(sb.size() == 0, {tag, " all beats seen"}, sb.size(), 0);
      @(posedge clk); #1;
    end
  endtask

  // monitor: compare each presented beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && beat_vld_o) begin
      if (sb.size() == 0) begin
        chk(0, "unexpected beat", col_o, 0);
      end else begin
        chk(col_o == sb[0].col[7:0], {sb[0].tag, " col"}, col_o, sb[0].col);
        chk(last_o == sb[0].last, {sb[0].tag, " last"}, last_o, sb[0].last);
        if (adv_i || stop_i || start_i) void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(beat_vld_o == 0 && last_o == 0 && col_o == 0, "R1 reset state",
        {beat_vld_o, last_o, col_o}, 0);
    @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;

    run(8'h35, 3'd2, 0, 0, 0, 4, 0, 0, 0, "R2 R3 R4 seq len4");
    run(8'h9B, 3'd3, 1, 0, 0, 8, 0, 1, 0, "R5 R8 ilv len8 stall");
    run(8'hFE, 3'd3, 0, 0, 0, 8, 0, 0, 0, "R4 seq len8 wrap");
    run(8'h12, 3'd2, 1, 0, 0, 4, 0, 0, 0, "R5 ilv len4");
    run(8'h41, 3'd1, 0, 0, 0, 2, 0, 1, 0, "R3 R7 seq len2");
    run(8'h77, 3'd0, 1, 0, 0, 1, 0, 0, 0, "R3 R7 len1");
    run(8'hFC, 3'd7, 1, 0, 0, 6, 1, 1, 0, "R6 page wrap");
    run(8'h20, 3'd3, 0, 0, 0, 3, 1, 0, 0, "R9 stop early");
    run(8'hA6, 3'd3, 1, 1, 1, 1, 0, 0, 0, "R11 write single");
    run(8'hA6, 3'd2, 0, 1, 0, 4, 0, 0, 0, "R11 write coded len");
    run(8'h5D, 3'd5, 0, 0, 0, 1, 0, 0, 0, "R3 reserved code");
    nxt_col = 8'h07; nxt_code = 3'd1; nxt_ilv = 0;
    run(8'hC3, 3'd3, 0, 0, 0, 3, 2, 0, 0, "R12 restart old");
    run(8'h07, 3'd1, 0, 0, 0, 2, 0, 0, 1, "R12 restart new R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule